// File: doc/BRIEF.md
# Keypad Event Controller with Hold Auto-Repeat

This block sits between an external keypad and a host processor. The keypad supplies a six-bit code and a key-down strobe. The five low code bits arrive already held by the keypad, and the block reads them live. The top code bit selects a key bank and is captured inside the block when a press is detected. Each new press raises an interrupt request. The host services the request by reading the key word, or by writing to an acknowledge location. The host read path drives data only while a read is in progress, and the block raises a separate drive-enable output for the shared data bus.

While the strobe stays high, a hold timer creates further key events. The first comes after a programmable initial delay, and the rest follow at a programmable repeat period. Both values are counted in system clock cycles and the host can write them. The strobe passes through a two-flop synchronizer before its edges are detected. The hold timer is a state machine with three states: HT_IDLE (no key held), HT_DELAY (counting the initial delay) and HT_REPEAT (counting repeat periods). Its transitions are:
- HT_IDLE to HT_DELAY on a synchronized rising strobe.
- HT_DELAY to HT_REPEAT when the delay count completes, which also produces an event.
- HT_REPEAT to HT_REPEAT when a period completes, which produces an event and restarts the count.
- HT_DELAY or HT_REPEAT to HT_IDLE whenever the synchronized strobe is low. This exit takes priority over any event.

Top module: `keypad_evt_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `rd_oe` is 0, the key word's flag bit is 0, the delay register reads DEF_DELAY (8192) and the period register reads DEF_PERIOD (1638).
- R2: A strobe that goes high between two clock edges sets `irq` on the third rising edge after it goes high. Edges are counted from the first edge that sees the strobe high.
- R3: Address 0 reads the key word. Bits 4:0 are the live `key_code[4:0]`, bit 5 is `key_code[5]` as it was when the press was detected, bit 6 is the overrun flag, and higher bits are 0.
- R4: `rd_oe` equals `host_rd`, and `rd_data` is 0 whenever `host_rd` is low. Address 1 reads the delay, address 2 reads the period, and address 3 reads 0.
- R5: Once set, `irq` stays high until either a host read of address 0 or a host write to address 3 is clocked. An event in that same cycle keeps it set.
- R6: While the key stays held, the first repeat sets `irq` exactly max(delay,1) cycles after the press's own `irq` edge.
- R7: Later repeats set `irq` every max(period,1) cycles while the key stays held.
- R8: If the strobe falls before clock edge f, no `irq` is set after edge f+1, and the next press starts again with the full initial delay.
- R9: An event that is clocked while `irq` is pending and not being cleared sets the overrun flag (key word bit 6). A read of address 0 clears it.
- R10: A host write to address 1 loads the delay register, and a host write to address 2 loads the period register. Each is CNT_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | 6 | Keypad code; bit 5 is bank select |
| key_down | input | 1 | Asynchronous key-pressed strobe |
| host_addr | input | 2 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | CNT_W | Host write data |
| host_rd | input | 1 | Host read strobe |
| rd_data | output | CNT_W | Read data, zero when not reading |
| rd_oe | output | 1 | Data bus drive enable |
| irq | output | 1 | Interrupt request to the host |

## Verification
Read data and `rd_oe` are combinational, so the bench samples them in the same cycle that `host_rd` is raised. The request caused by a press is due two edges after the first edge that sees the strobe. Each repeat is due exactly delay, and then period, cycles after the previous request. The last request that can still appear after a release is due one edge after the release edge.

The bench keeps a posedge count and samples `irq` at falling edges. It logs the edge of each rising `irq` and compares the list with a schedule worked out from the press edge, the release edge, the delay and the period. A separate acknowledge driver clears each request one cycle after it appears, so that every request shows up as a new rising edge.

// File: rtl/keypad_evt_pkg.sv
package keypad_evt_pkg;
    typedef enum logic [1:0] {
        HT_IDLE   = 2'd0,
        HT_DELAY  = 2'd1,
        HT_REPEAT = 2'd2
    } hold_st_e;

    localparam logic [1:0] A_KEY    = 2'd0;
    localparam logic [1:0] A_DELAY  = 2'd1;
    localparam logic [1:0] A_PERIOD = 2'd2;
    localparam logic [1:0] A_ACK    = 2'd3;
endpackage

// File: rtl/kp_strobe_sync.sv
module kp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              lvl_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= async_in;
                else
                    chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/kp_hold_timer.sv
module kp_hold_timer
    import keypad_evt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             held,
    input  logic             press,
    input  logic [CNT_W-1:0] delay_lim,
    input  logic [CNT_W-1:0] period_lim,
    output logic             rep_evt,
    output hold_st_e         st
);
    hold_st_e         st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= HT_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        rep_evt = 1'b0;
        unique case (st)
            HT_IDLE: begin
                cnt_nxt = '0;
                if (press) st_nxt = HT_DELAY;
            end
            HT_DELAY: begin
                if (!held) begin
                    st_nxt  = HT_IDLE;
                    cnt_nxt = '0;
                end else if (cnt_inc >= {1'b0, delay_lim}) begin
                    rep_evt = 1'b1;
                    st_nxt  = HT_REPEAT;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_inc[CNT_W-1:0];
                end
            end
            HT_REPEAT: begin
                if (!held) begin
                    st_nxt  = HT_IDLE;
                    cnt_nxt = '0;
                end else if (cnt_inc >= {1'b0, period_lim}) begin
                    rep_evt = 1'b1;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                st_nxt  = HT_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end
endmodule

// File: rtl/kp_irq_ctrl.sv
module kp_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic key_rd,
    output logic irq,
    output logic ovr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            ovr <= 1'b0;
        end else begin
            if (evt)      irq <= 1'b1;
            else if (clr) irq <= 1'b0;

            if (evt && irq && !clr) ovr <= 1'b1;
            else if (key_rd)        ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/keypad_evt_ctrl.sv
module keypad_evt_ctrl
    import keypad_evt_pkg::*;
#(
    parameter int               CNT_W      = 24,
    parameter int               SYNC_STG   = 2,
    parameter logic [CNT_W-1:0] DEF_DELAY  = 24'd8192,
    parameter logic [CNT_W-1:0] DEF_PERIOD = 24'd1638
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       key_code,
    input  logic             key_down,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic [CNT_W-1:0] host_wdata,
    input  logic             host_rd,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_oe,
    output logic             irq
);
    localparam int KW = 7;

    logic             held, press, rep_evt, evt, clr, key_rd, ovr;
    logic             bank_q;
    logic [CNT_W-1:0] delay_q, period_q;
    hold_st_e         ht_st;

    kp_strobe_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(key_down),
        .lvl(held), .rise(press)
    );

    kp_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .held(held), .press(press),
        .delay_lim(delay_q), .period_lim(period_q),
        .rep_evt(rep_evt), .st(ht_st)
    );

    assign evt    = press | rep_evt;
    assign key_rd = host_rd && (host_addr == A_KEY);
    assign clr    = key_rd || (host_wr && (host_addr == A_ACK));

    kp_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr),
        .key_rd(key_rd), .irq(irq), .ovr(ovr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= 1'b0;
            delay_q  <= DEF_DELAY;
            period_q <= DEF_PERIOD;
        end else begin
            if (press) bank_q <= key_code[5];
            if (host_wr && host_addr == A_DELAY)  delay_q  <= host_wdata;
            if (host_wr && host_addr == A_PERIOD) period_q <= host_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (host_rd) begin
            unique case (host_addr)
                A_KEY:    rd_data[KW-1:0] = {ovr, bank_q, key_code[4:0]};
                A_DELAY:  rd_data = delay_q;
                A_PERIOD: rd_data = period_q;
                default:  rd_data = '0;
            endcase
        end
    end

    assign rd_oe = host_rd;
endmodule

// File: rtl/keypad_evt_ctrl_chk.sv
module keypad_evt_ctrl_chk
    import keypad_evt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_rd,
    input logic [CNT_W-1:0] rd_data,
    input logic             rd_oe,
    input logic             irq,
    input logic             evt,
    input logic             clr,
    input logic             ovr,
    input logic             held,
    input hold_st_e         ht_st
);
    // R2
    irq_on_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> irq);

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !irq);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq && !clr) |=> ovr);

    // R8
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> (ht_st == HT_IDLE));

    // R4
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |-> (rd_data == '0 && !rd_oe));
endmodule

bind keypad_evt_ctrl keypad_evt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .rd_data(rd_data),
    .rd_oe(rd_oe), .irq(irq), .evt(evt), .clr(clr), .ovr(ovr),
    .held(held), .ht_st(ht_st)
);

// File: tb/test_keypad_evt_ctrl.sv
module test_keypad_evt_ctrl;
    localparam int CNT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       key_code = '0;
    logic             key_down = 1'b0;
    logic [1:0]       tb_addr = '0;
    logic             tb_wr = 1'b0;
    logic             ack_wr = 1'b0;
    logic [CNT_W-1:0] host_wdata = '0;
    logic             host_rd = 1'b0;
    logic [1:0]       host_addr;
    logic             host_wr;
    logic [CNT_W-1:0] rd_data;
    logic             rd_oe;
    logic             irq;

    assign host_wr   = tb_wr | ack_wr;
    assign host_addr = ack_wr ? 2'd3 : tb_addr;

    keypad_evt_ctrl #(.CNT_W(CNT_W)) i_keypad_evt_ctrl (
        .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_down(key_down),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .rd_data(rd_data), .rd_oe(rd_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit auto_ack = 1'b0;
    bit irq_prev = 1'b0;
    bit done = 1'b0;
    int rise_t [0:63];
    int n_rise = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        ack_wr <= 1'b0;
        if (irq && !irq_prev) begin
            if (n_rise < 64) rise_t[n_rise] = cyc;
            n_rise = n_rise + 1;
            if (auto_ack) ack_wr <= 1'b1;
        end
        irq_prev = irq;
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(logic [1:0] a, logic [CNT_W-1:0] d);
        @(negedge clk);
        tb_addr = a; host_wdata = d; tb_wr = 1'b1;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic host_read(logic [1:0] a, output logic [CNT_W-1:0] d, output logic oe);
        @(negedge clk);
        tb_addr = a; host_rd = 1'b1;
        #2;
        d = rd_data; oe = rd_oe;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic longint key_word(bit ovr, bit bank, logic [4:0] low);
        return longint'({ovr, bank, low});
    endfunction

    logic [CNT_W-1:0] rv;
    logic             oe;

    initial begin
        void'($urandom(32'd1234));
        wait_cyc(3);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 rd_oe", rd_oe, 0);
        host_read(2'd1, rv, oe);
        check("R1 delay default", rv, 8192);
        host_read(2'd2, rv, oe);
        check("R1 period default", rv, 1638);
        host_read(2'd0, rv, oe);
        check("R1 key word", rv, 0);

        // R10 / R4 register access
        host_write(2'd1, 24'd17);
        host_write(2'd2, 24'd9);
        host_read(2'd1, rv, oe);
        check("R10 delay", rv, 17);
        check("R4 oe during read", oe, 1);
        host_read(2'd2, rv, oe);
        check("R10 period", rv, 9);
        host_read(2'd3, rv, oe);
        check("R4 addr3 reads zero", rv, 0);
        #2;
        check("R4 oe idle", rd_oe, 0);
        check("R4 data idle", rd_data, 0);

        // R2/R5/R9: delay 0 clamps to 1, no ack -> overrun
        host_write(2'd1, 24'd0);
        host_write(2'd2, 24'd1000);
        key_code = 6'b1_01011;
        @(negedge clk);
        key_down = 1'b1;
        n_rise = 0;
        begin
            int pe;
            pe = cyc + 1;
            wait_cyc(8);
            check("R2 first irq edge", rise_t[0], pe + 2);
            check("R5 irq stays pending", irq, 1);
        end
        key_code[5] = 1'b0;
        host_read(2'd0, rv, oe);
        check("R9 overrun set / R3 bank latched", rv, key_word(1, 1, 5'b01011));
        #2;
        check("R5 key read clears irq", irq, 0);
        host_read(2'd0, rv, oe);
        check("R9 overrun cleared by read", rv, key_word(0, 1, 5'b01011));
        @(negedge clk);
        key_down = 1'b0;
        wait_cyc(5);
        host_write(2'd3, 0);
        #2;
        check("R5 ack write clears irq", irq, 0);
        wait_cyc(30);
        check("R8 no irq after release", irq, 0);

        // R6/R7/R8 random holds against computed schedule
        auto_ack = 1'b1;
        for (int it = 0; it < 24; it++) begin
            int d, p, h, pe, fe, n_exp, t;
            logic [5:0] kc;
            d  = 3 + int'($urandom_range(37));
            p  = 3 + int'($urandom_range(27));
            h  = 1 + int'($urandom_range(149));
            if (it == 0) h = 1;
            if (it == 1) begin d = 3; p = 3; h = 120; end
            kc = 6'($urandom);
            host_write(2'd1, CNT_W'(d));
            host_write(2'd2, CNT_W'(p));
            key_code = kc;
            @(negedge clk);
            key_down = 1'b1;
            n_rise = 0;
            pe = cyc + 1;
            wait_cyc(h);
            key_down = 1'b0;
            fe = pe + h;
            wait_cyc(6);
            key_code[5] = ~kc[5];
            n_exp = 0;
            t = pe + 2;
            while (t <= fe + 1) begin
                if (n_exp < 64 && n_exp < n_rise) begin
                    if (n_exp == 0)
                        check("R2 press irq edge", rise_t[0], t);
                    else if (n_exp == 1)
                        check("R6 first repeat edge", rise_t[1], t);
                    else
                        check("R7 repeat edge", rise_t[n_exp], t);
                end
                n_exp++;
                t += (n_exp == 1) ? d : p;
            end
            check("R8 events per hold", n_rise, n_exp);
            host_read(2'd0, rv, oe);
            check("R3 key word after hold", rv, key_word(0, kc[5], kc[4:0]));
            wait_cyc(2);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule